// File: doc/BRIEF.md
# UART Transmitter with Break and Idle Preamble

This block serialises characters onto a single transmit line. A character is written into a one-entry holding register and, on a later baud tick, is moved into a shift register. From there it goes out as a start bit (0), then the data bits least significant first, then a stop bit (1). Each bit lasts exactly one baud tick period. A mode input selects 8 or 9 data bits, so a frame is 10 or 11 bit times long. The baud tick comes from an external divider as a one-clock pulse.

The block also sends two special frames of the same length. While the break request is high, frames of all zeros go out back to back. A short pulse on the break request is captured and produces exactly one such frame. A 0-to-1 transition of the enable queues one all-ones idle frame, which is sent before any waiting data. When the enable is low, the frame already under way finishes, and after that the line stays high.

The controller has four states. ST_IDLE means the line is high and no frame is running. ST_DATA, ST_BREAK and ST_PREAMBLE are the three kinds of frame. A frame can start only on a baud tick, and only from ST_IDLE or on the tick that ends the current frame. At that point the controller picks the next state in this priority order: ST_PREAMBLE (a preamble is pending), then ST_BREAK (a break is requested), then ST_DATA (the holding register is full). All three require the enable to be high. If none applies, the controller returns to ST_IDLE.

Top module: `uart_tx_brk`

## Requirements
- R1: After reset, txd is 1, buf_empty is 1 and tx_done is 1.
- R2: In 8-bit mode (nine_bit=0), a written byte goes out as 0, then wr_data[0] to wr_data[7], then 1. Each bit lasts one tick period. The start bit appears on the first baud tick after the write, provided the enable is high and no frame is running.
- R3: In 9-bit mode (nine_bit=1), the frame is 11 bits long, and wr_data[8] is sent as the last data bit before the stop bit.
- R4: A character written during a frame starts on the tick that ends that frame, with no idle bit in between. buf_empty returns to 1 on the tick that loads the character.
- R5: While brk_req is held high, txd stays 0 in whole frames. When brk_req falls, the frame in progress still runs its full length before the line returns high.
- R6: A brk_req pulse one clock long produces exactly one all-zero frame: 10 bit times in 8-bit mode, 11 in 9-bit mode. The line then goes high.
- R7: A 0-to-1 transition of tx_en queues one all-ones frame of 10 or 11 bit times. This frame is sent before any character that is waiting. Taking tx_en low discards a preamble that has not yet started.
- R8: A character written during a break or preamble frame stays in the holding register, with buf_empty at 0. It is sent right after that frame ends.
- R9: tx_done is 1 exactly when no frame is running and the holding register is empty.
- R10: When tx_en falls in the middle of a frame, that frame completes. After that, txd stays high and no new frame starts, and a waiting character stays held, while tx_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-clock pulse per bit time |
| tx_en | input | 1 | Transmit enable |
| brk_req | input | 1 | Break request |
| nine_bit | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| wr_stb | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W (9) | Character to send; bit 8 is used only in 9-bit mode |
| txd | output | 1 | Serial line, high when idle |
| buf_empty | output | 1 | Holding register empty |
| tx_done | output | 1 | No frame running and holding register empty |

## Verification
A new bit appears on txd at the same clock edge that samples baud_tick high. buf_empty rises at that same edge when a character is loaded, and tx_done follows from the registered state without further delay. The bench drives each tick as a single-clock pulse and leaves two idle clocks after it. It samples txd, buf_empty and tx_done on the falling edge after the tick edge, so each bit is checked once per bit time. Writes and level changes on brk_req and tx_en are applied on a falling edge, between ticks. A frame boundary can therefore be counted exactly in ticks. For example, the start bit of waiting data is due on the 11th tick after an 8-bit preamble begins.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_DATA     = 2'd1,
        ST_BREAK    = 2'd2,
        ST_PREAMBLE = 2'd3
    } tx_state_t;
endpackage

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] data
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full <= 1'b0;
            data <= '0;
        end else if (wr_stb) begin
            full <= 1'b1;
            data <= wr_data;
        end else if (take) begin
            full <= 1'b0;
        end
    end

    // the controller only moves a character when one is held
    assert_take_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> full);
endmodule

// File: rtl/uart_tx_req.sv
module uart_tx_req (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_en,
    input  logic brk_req,
    input  logic pre_take,
    input  logic brk_take,
    output logic pre_pend,
    output logic brk_want
);
    logic en_q, brk_q, brk_pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q       <= 1'b0;
            brk_q      <= 1'b0;
            pre_pend   <= 1'b0;
            brk_pend_q <= 1'b0;
        end else begin
            en_q  <= tx_en;
            brk_q <= brk_req;
            if (!tx_en)
                pre_pend <= 1'b0;
            else if (!en_q)
                pre_pend <= 1'b1;
            else if (pre_take)
                pre_pend <= 1'b0;
            if (brk_take)
                brk_pend_q <= 1'b0;
            else if (brk_req && !brk_q)
                brk_pend_q <= 1'b1;
        end
    end

    // level keeps breaks going; the captured edge covers short pulses
    assign brk_want = brk_req | brk_pend_q;

    assert_pre_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> !pre_pend);
endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift import uart_tx_pkg::*; #(
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              run,
    input  logic              load,
    input  tx_state_t         kind,
    input  logic              nine,
    input  logic [DATA_W-1:0] data,
    output logic              txd,
    output logic              last
);
    localparam int FRAME_W = DATA_W + 2;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    logic [FRAME_W-1:0] sh_q, frame_val;
    logic [CNT_W-1:0]   cnt_q, len_q, len_val;

    always_comb begin
        unique case (kind)
            ST_BREAK:    frame_val = '0;
            ST_PREAMBLE: frame_val = '1;
            default:     frame_val = nine ? {1'b1, data, 1'b0}
                                          : {2'b11, data[DATA_W-2:0], 1'b0};
        endcase
        len_val = nine ? CNT_W'(FRAME_W) : CNT_W'(FRAME_W - 1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= '1;
            cnt_q <= '0;
            len_q <= CNT_W'(FRAME_W - 1);
        end else if (load) begin
            sh_q  <= frame_val;
            cnt_q <= '0;
            len_q <= len_val;
        end else if (run && tick) begin
            sh_q  <= {1'b1, sh_q[FRAME_W-1:1]};
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign txd  = run ? sh_q[0] : 1'b1;
    assign last = run && (cnt_q == len_q - CNT_W'(1));

    assert_cnt_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q < len_q));
endmodule

// File: rtl/uart_tx_ctrl.sv
module uart_tx_ctrl import uart_tx_pkg::*; (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      last,
    input  logic      tx_en,
    input  logic      pre_pend,
    input  logic      brk_want,
    input  logic      buf_full,
    output tx_state_t state_q,
    output logic      load,
    output tx_state_t load_kind,
    output logic      pre_take,
    output logic      brk_take,
    output logic      buf_take
);
    tx_state_t state_d, pick;
    logic      slot;

    always_comb begin
        if (tx_en && pre_pend)
            pick = ST_PREAMBLE;
        else if (tx_en && brk_want)
            pick = ST_BREAK;
        else if (tx_en && buf_full)
            pick = ST_DATA;
        else
            pick = ST_IDLE;

        state_d = state_q;
        slot    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                slot = tick;
            end
            ST_DATA, ST_BREAK, ST_PREAMBLE: begin
                slot = tick && last;
            end
        endcase
        if (slot)
            state_d = pick;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        load      = slot && (pick != ST_IDLE);
        load_kind = pick;
        pre_take  = slot && (pick == ST_PREAMBLE);
        brk_take  = slot && (pick == ST_BREAK);
        buf_take  = slot && (pick == ST_DATA);
    end

    assert_no_start_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !tx_en) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/uart_tx_brk.sv
module uart_tx_brk import uart_tx_pkg::*; #(
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              tx_en,
    input  logic              brk_req,
    input  logic              nine_bit,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    output logic              txd,
    output logic              buf_empty,
    output logic              tx_done
);
    tx_state_t         state, load_kind;
    logic              load, pre_take, brk_take, buf_take;
    logic              pre_pend, brk_want, buf_full, last;
    logic [DATA_W-1:0] hold_data;
    logic              run;

    assign run = (state != ST_IDLE);

    uart_tx_hold #(.DATA_W(DATA_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
        .take(buf_take), .full(buf_full), .data(hold_data)
    );

    uart_tx_req u_req (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .brk_req(brk_req),
        .pre_take(pre_take), .brk_take(brk_take),
        .pre_pend(pre_pend), .brk_want(brk_want)
    );

    uart_tx_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .tick(baud_tick), .last(last),
        .tx_en(tx_en), .pre_pend(pre_pend), .brk_want(brk_want),
        .buf_full(buf_full), .state_q(state), .load(load),
        .load_kind(load_kind), .pre_take(pre_take),
        .brk_take(brk_take), .buf_take(buf_take)
    );

    uart_tx_shift #(.DATA_W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .tick(baud_tick), .run(run),
        .load(load), .kind(load_kind), .nine(nine_bit),
        .data(hold_data), .txd(txd), .last(last)
    );

    assign buf_empty = !buf_full;
    assign tx_done   = !run && !buf_full;

    assert_data_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (load && load_kind == ST_DATA) |=> !txd);
    assert_break_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BREAK) |-> !txd);
    assert_pre_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PREAMBLE) |-> txd);
    assert_done_line_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> txd);
endmodule

// File: tb/uart_tx_brk_test.sv
`timescale 1ns/1ps
module uart_tx_brk_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0, tx_en = 1'b0, brk_req = 1'b0;
    logic       nine_bit = 1'b0, wr_stb = 1'b0;
    logic [8:0] wr_data = '0;
    logic       txd, buf_empty, tx_done;
    int         errs = 0, checks = 0;
    bit         ended = 1'b0;

    always #10 clk = ~clk;

    uart_tx_brk uut (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .tx_en(tx_en),
        .brk_req(brk_req), .nine_bit(nine_bit), .wr_stb(wr_stb),
        .wr_data(wr_data), .txd(txd), .buf_empty(buf_empty), .tx_done(tx_done)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_tick();
        @(negedge clk) baud_tick = 1'b1;
        @(negedge clk) baud_tick = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic write(input logic [8:0] d);
        @(negedge clk) begin wr_stb = 1'b1; wr_data = d; end
        @(negedge clk) wr_stb = 1'b0;
    endtask

    task automatic expect_bits(input string req, input int n, input logic [15:0] exp);
        for (int i = 0; i < n; i++) begin
            do_tick();
            chk(req, txd, exp[i]);
        end
    endtask

    function automatic logic [15:0] frame8(input logic [7:0] d);
        return {6'b0, 1'b1, d, 1'b0};
    endfunction

    function automatic logic [15:0] frame9(input logic [8:0] d);
        return {5'b0, 1'b1, d, 1'b0};
    endfunction

    task automatic test_reset();
        chk("R1 txd", txd, 1);
        chk("R1 buf_empty", buf_empty, 1);
        chk("R1 tx_done", tx_done, 1);
    endtask

    task automatic test_disabled_hold();
        write(9'h055);
        repeat (3) begin
            do_tick();
            chk("R10 idle while disabled", txd, 1);
        end
        chk("R10 data held", buf_empty, 0);
        chk("R9 done low with data", tx_done, 0);
    endtask

    task automatic test_preamble_first();
        @(negedge clk) tx_en = 1'b1;
        do_tick();
        chk("R7 preamble bit", txd, 1);
        chk("R9 done low in preamble", tx_done, 0);
        chk("R8 data waits in preamble", buf_empty, 0);
        expect_bits("R7 preamble", 9, 16'hFFFF);
        expect_bits("R2 data after preamble", 10, frame8(8'h55));
        do_tick();
        chk("R2 line idle", txd, 1);
        chk("R9 done", tx_done, 1);
    endtask

    task automatic test_back_to_back();
        logic [15:0] f1;
        f1 = frame8(8'hA3);
        write(9'h0A3);
        do_tick();
        chk("R2 start", txd, 0);
        chk("R4 empty on load", buf_empty, 1);
        write(9'h05C);
        chk("R4 second held", buf_empty, 0);
        for (int i = 1; i < 10; i++) begin
            do_tick();
            chk("R2 first frame", txd, f1[i]);
        end
        expect_bits("R4 second frame", 10, frame8(8'h5C));
        do_tick();
        chk("R4 idle after", txd, 1);
    endtask

    task automatic test_nine();
        @(negedge clk) nine_bit = 1'b1;
        write(9'h1A5);
        expect_bits("R3 nine-bit frame", 11, frame9(9'h1A5));
        do_tick();
        chk("R3 idle after", txd, 1);
        @(negedge clk) nine_bit = 1'b0;
    endtask

    task automatic test_break_pulse();
        @(negedge clk) brk_req = 1'b1;
        @(negedge clk) brk_req = 1'b0;
        write(9'h00F);
        do_tick();
        chk("R6 break bit", txd, 0);
        chk("R8 data waits in break", buf_empty, 0);
        expect_bits("R6 break 8-bit", 9, 16'h0000);
        expect_bits("R8 data after break", 10, frame8(8'h0F));
        do_tick();
        chk("R6 idle", txd, 1);
        @(negedge clk) nine_bit = 1'b1;
        @(negedge clk) brk_req = 1'b1;
        @(negedge clk) brk_req = 1'b0;
        expect_bits("R6 break 9-bit", 11, 16'h0000);
        do_tick();
        chk("R6 idle after 9-bit break", txd, 1);
        @(negedge clk) nine_bit = 1'b0;
    endtask

    task automatic test_break_hold();
        @(negedge clk) brk_req = 1'b1;
        expect_bits("R5 held break", 15, 16'h0000);
        @(negedge clk) brk_req = 1'b0;
        expect_bits("R5 frame finishes", 5, 16'h0000);
        expect_bits("R5 idle after", 2, 16'hFFFF);
    endtask

    task automatic test_te_drop();
        logic [15:0] f;
        f = frame8(8'h81);
        write(9'h081);
        do_tick();
        chk("R10 start", txd, 0);
        do_tick();
        chk("R10 bit1", txd, f[1]);
        @(negedge clk) tx_en = 1'b0;
        for (int i = 2; i < 10; i++) begin
            do_tick();
            chk("R10 frame completes", txd, f[i]);
        end
        write(9'h042);
        repeat (3) begin
            do_tick();
            chk("R10 stays idle", txd, 1);
        end
        chk("R10 held while off", buf_empty, 0);
        @(negedge clk) tx_en = 1'b1;
        expect_bits("R7 re-enable preamble", 10, 16'hFFFF);
        expect_bits("R7 data after preamble", 10, frame8(8'h42));
        do_tick();
        chk("R9 done at end", tx_done, 1);
    endtask

    initial begin
        #(20 * 100000);
        if (!ended) begin
            errs++;
            checks++;
            $display("FAIL watchdog: got 0 expected 1");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_disabled_hold();
        test_preamble_first();
        test_back_to_back();
        test_nine();
        test_break_pulse();
        test_break_hold();
        test_te_drop();
        ended = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule